// File: doc/BRIEF.md
# Network Controller Suspend Sequencer

This block moves a network controller from normal operation into a quiet, suspended state when the host asks for it, and back out again when the host withdraws the request. The host drives a level request bit; the sequencer answers with a status bit. The status bit goes high only once the datapath has actually settled. While the sequencer is suspending or suspended, it drives four inhibit lines that stop new work from starting. These lines cover transmit descriptor fetches, transmit launches on the wire, reception from the wire, and receive stores to memory. In normal mode it also drives a flush request.

Two entry policies exist, and the choice is captured when the request is accepted. The fast policy lets transfers and frames already under way finish and then stops. Data may remain queued. The normal policy blocks new receptions and new transmit fetches, waits for the work in flight to end, and then empties both queues. The queued transmit frames go out on the wire and the queued receive frames go into memory. Clearing the request leaves suspension through a one-cycle resume step, and no re-initialization is needed. A software reset, a STOP command or a hardware reset abandons the sequence and marks the controller as needing initialization.

Top module: `suspend_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all four holds, `flush_req` and `spnd_rd` are 0 and `need_init` is 1.
- R2: With `need_init` 0, a clock edge that sees `spnd_wr`=1 in the running state starts the suspend sequence. `spnd_rd` stays 0 until the suspended state is reached.
- R3: In fast mode, all four holds are 1 and `flush_req` is 0 during entry. Suspension is reached on the edge after which all four busy flags are seen low, whatever the queue-empty flags say.
- R4: In normal mode's first stage, `hold_tx_fetch`=1, `hold_rx_accept`=1, `hold_tx_launch`=0, `hold_rx_store`=0 and `flush_req`=1. The stage ends on an edge that sees `tx_dma_busy`=0 and `rx_mac_busy`=0.
- R5: Normal mode's second stage keeps the same outputs as R4. It reaches suspension only on an edge that sees both queue-empty flags at 1 and `tx_mac_busy`=0 and `rx_dma_busy`=0.
- R6: When suspended, `spnd_rd`=1, all four holds are 1 and `flush_req`=0. This holds for as long as `spnd_wr` stays 1.
- R7: An edge that sees `spnd_wr`=0 while suspended leads to exactly one resume cycle with all outputs 0 except `need_init`, which is unchanged at 0. The block then runs again.
- R8: The fast/normal choice is taken from `fast_en` at the edge that accepts the request. Changes to `fast_en` afterwards have no effect on that sequence.
- R9: An edge that sees `spnd_wr`=0 during either entry stage returns the block to running, with all holds and `flush_req` at 0 in the next cycle.
- R10: An edge that sees `soft_rst`=1 or `stop_cmd`=1 forces the running state with `need_init`=1, whatever state the block was in. This takes priority over every other input.
- R11: While `need_init`=1, `spnd_wr` is ignored. An edge that sees `init_done`=1 without `soft_rst` or `stop_cmd` clears `need_init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Software reset command |
| stop_cmd | input | 1 | STOP command |
| init_done | input | 1 | Initialization finished |
| spnd_wr | input | 1 | Host suspend request level |
| fast_en | input | 1 | 1 selects the fast entry policy |
| tx_dma_busy | input | 1 | Transmit DMA transfer in progress |
| tx_mac_busy | input | 1 | Frame being transmitted on the wire |
| rx_mac_busy | input | 1 | Frame being received from the wire |
| rx_dma_busy | input | 1 | Receive DMA transfer in progress |
| tx_q_empty | input | 1 | Transmit queue holds no frame |
| rx_q_empty | input | 1 | Receive queue holds no frame |
| hold_tx_fetch | output | 1 | Block new transmit DMA fetches |
| hold_tx_launch | output | 1 | Block new transmit frames |
| hold_rx_accept | output | 1 | Block new receptions |
| hold_rx_store | output | 1 | Block new receive DMA stores |
| flush_req | output | 1 | Ask the datapath to empty its queues |
| spnd_rd | output | 1 | Suspend status read-back |
| need_init | output | 1 | Controller must be re-initialized |

## Verification
The properties do not assume a well-behaved datapath. A busy flag may rise even while its inhibit is set, and the sequencer must simply wait for it to fall. The random stimulus therefore toggles every busy and queue flag freely on each cycle. The only thing taken for granted is that `rst` is high from time zero for at least one edge, which the bench provides. Reset-class inputs are kept rare in the random phase so that full entry and resume sequences occur often.

// File: rtl/suspend_pkg.sv
package suspend_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_DRAIN  = 3'd1,
        ST_FLUSH  = 3'd2,
        ST_SUSP   = 3'd3,
        ST_RESUME = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic tx_fetch;
        logic tx_launch;
        logic rx_accept;
        logic rx_store;
    } hold_t;

    typedef struct packed {
        logic tx_dma;
        logic tx_mac;
        logic rx_mac;
        logic rx_dma;
    } activity_t;

    localparam hold_t HOLD_NONE = '0;
    localparam hold_t HOLD_ALL  = '1;
    localparam hold_t HOLD_INPUT_SIDE = '{tx_fetch: 1'b1, tx_launch: 1'b0,
                                          rx_accept: 1'b1, rx_store: 1'b0};

    function automatic logic is_entering(seq_state_e s);
        return (s == ST_DRAIN) || (s == ST_FLUSH);
    endfunction

    function automatic hold_t hold_for(seq_state_e s, logic fast);
        hold_t h;
        case (s)
            ST_SUSP:            h = HOLD_ALL;
            ST_DRAIN, ST_FLUSH: h = fast ? HOLD_ALL : HOLD_INPUT_SIDE;
            default:            h = HOLD_NONE;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/spnd_ctrl_regs.sv
module spnd_ctrl_regs
    import suspend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic init_done,
    input  logic accept,
    input  logic fast_en,
    output logic fast_mode,
    output logic need_init
);

    always_ff @(posedge clk) begin
        if (rst) begin
            need_init <= 1'b1;
        end else if (kill) begin
            need_init <= 1'b1;
        end else if (init_done) begin
            need_init <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fast_mode <= 1'b0;
        end else if (accept) begin
            fast_mode <= fast_en;
        end
    end

    AST_KILL_SETS_INIT: assert property (@(posedge clk) disable iff (rst)
        kill |=> need_init) else $error("kill did not set need_init"); // R10

    AST_MODE_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(fast_mode)) else $error("mode moved without request"); // R8

endmodule

// File: rtl/spnd_idle_eval.sv
module spnd_idle_eval
    import suspend_pkg::*;
(
    input  activity_t act,
    input  logic      tx_q_empty,
    input  logic      rx_q_empty,
    input  logic      fast_mode,
    output logic      drain_done,
    output logic      flush_done
);

    logic inflight_all_idle;
    logic inflight_in_idle;
    logic queues_idle;

    always_comb begin
        inflight_all_idle = (act == '0);
        inflight_in_idle  = !act.tx_dma && !act.rx_mac;
        queues_idle       = tx_q_empty && rx_q_empty && !act.tx_mac && !act.rx_dma;
        drain_done        = fast_mode ? inflight_all_idle : inflight_in_idle;
        flush_done        = queues_idle;
    end

endmodule

// File: rtl/spnd_fsm.sv
module spnd_fsm
    import suspend_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       kill,
    input  logic       spnd_wr,
    input  logic       need_init,
    input  logic       fast_mode,
    input  logic       drain_done,
    input  logic       flush_done,
    output logic       accept,
    output seq_state_e state
);

    seq_state_e nxt;

    always_comb begin
        accept = (state == ST_RUN) && spnd_wr && !need_init && !kill;
    end

    always_comb begin
        nxt = state;
        if (kill) begin
            nxt = ST_RUN;
        end else begin
            case (state)
                ST_RUN:    if (accept) nxt = ST_DRAIN;
                ST_DRAIN: begin
                    if (!spnd_wr)        nxt = ST_RUN;
                    else if (drain_done) nxt = fast_mode ? ST_SUSP : ST_FLUSH;
                end
                ST_FLUSH: begin
                    if (!spnd_wr)        nxt = ST_RUN;
                    else if (flush_done) nxt = ST_SUSP;
                end
                ST_SUSP:   if (!spnd_wr) nxt = ST_RESUME;
                ST_RESUME: nxt = ST_RUN;
                default:   nxt = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= nxt;
    end

    AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RESUME) |=> (state == ST_RUN)) else $error("resume too long"); // R7

    AST_SUSP_VIA_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUSP && $past(state) != ST_SUSP) |-> is_entering($past(state)))
        else $error("suspend reached without entry"); // R2

    AST_FAST_SKIPS_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLUSH) |-> !fast_mode) else $error("fast mode in flush"); // R5

    AST_ABORT_TO_RUN: assert property (@(posedge clk) disable iff (rst)
        (is_entering(state) && !spnd_wr && !kill) |=> (state == ST_RUN))
        else $error("abort ignored"); // R9

    AST_KILL_TO_RUN: assert property (@(posedge clk) disable iff (rst)
        kill |=> (state == ST_RUN)) else $error("kill ignored"); // R10

    AST_NO_START_UNINIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && need_init) |=> (state == ST_RUN)) else $error("started while uninitialized"); // R11

endmodule

// File: rtl/spnd_out_decode.sv
module spnd_out_decode
    import suspend_pkg::*;
(
    input  seq_state_e state,
    input  logic       fast_mode,
    output hold_t      holds,
    output logic       flush_req,
    output logic       spnd_rd
);

    always_comb begin
        holds     = hold_for(state, fast_mode);
        flush_req = is_entering(state) && !fast_mode;
        spnd_rd   = (state == ST_SUSP);
    end

endmodule

// File: rtl/suspend_seq.sv
module suspend_seq
    import suspend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic stop_cmd,
    input  logic init_done,
    input  logic spnd_wr,
    input  logic fast_en,
    input  logic tx_dma_busy,
    input  logic tx_mac_busy,
    input  logic rx_mac_busy,
    input  logic rx_dma_busy,
    input  logic tx_q_empty,
    input  logic rx_q_empty,
    output logic hold_tx_fetch,
    output logic hold_tx_launch,
    output logic hold_rx_accept,
    output logic hold_rx_store,
    output logic flush_req,
    output logic spnd_rd,
    output logic need_init
);

    logic       kill;
    logic       accept;
    logic       fast_mode;
    logic       drain_done;
    logic       flush_done;
    activity_t  act;
    hold_t      holds;
    seq_state_e state;

    always_comb begin
        kill       = soft_rst || stop_cmd;
        act.tx_dma = tx_dma_busy;
        act.tx_mac = tx_mac_busy;
        act.rx_mac = rx_mac_busy;
        act.rx_dma = rx_dma_busy;
    end

    spnd_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .kill      (kill),
        .init_done (init_done),
        .accept    (accept),
        .fast_en   (fast_en),
        .fast_mode (fast_mode),
        .need_init (need_init)
    );

    spnd_idle_eval u_idle (
        .act        (act),
        .tx_q_empty (tx_q_empty),
        .rx_q_empty (rx_q_empty),
        .fast_mode  (fast_mode),
        .drain_done (drain_done),
        .flush_done (flush_done)
    );

    spnd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .kill       (kill),
        .spnd_wr    (spnd_wr),
        .need_init  (need_init),
        .fast_mode  (fast_mode),
        .drain_done (drain_done),
        .flush_done (flush_done),
        .accept     (accept),
        .state      (state)
    );

    spnd_out_decode u_dec (
        .state     (state),
        .fast_mode (fast_mode),
        .holds     (holds),
        .flush_req (flush_req),
        .spnd_rd   (spnd_rd)
    );

    always_comb begin
        hold_tx_fetch  = holds.tx_fetch;
        hold_tx_launch = holds.tx_launch;
        hold_rx_accept = holds.rx_accept;
        hold_rx_store  = holds.rx_store;
    end

    AST_SUSP_HOLDS_ALL: assert property (@(posedge clk) disable iff (rst)
        spnd_rd |-> (hold_tx_fetch && hold_tx_launch && hold_rx_accept && hold_rx_store && !flush_req))
        else $error("suspended without full hold"); // R6

    AST_FLUSH_NOT_FAST: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> (!hold_tx_launch && !hold_rx_store && hold_tx_fetch && hold_rx_accept))
        else $error("flush with wrong holds"); // R4

    AST_SUSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(spnd_rd) |-> $past(spnd_wr)) else $error("suspended without request"); // R2

endmodule

// File: tb/suspend_seq_test.sv
module suspend_seq_test;

    logic clk = 1'b0;
    logic rst, soft_rst, stop_cmd, init_done, spnd_wr, fast_en;
    logic tx_dma_busy, tx_mac_busy, rx_mac_busy, rx_dma_busy, tx_q_empty, rx_q_empty;
    logic hold_tx_fetch, hold_tx_launch, hold_rx_accept, hold_rx_store;
    logic flush_req, spnd_rd, need_init;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model: 0 run, 1 drain, 2 flush, 3 suspended, 4 resume
    int   m_st   = 0;
    logic m_fast = 1'b0;
    logic m_init = 1'b1;

    always #4 clk = ~clk;

    suspend_seq uut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .stop_cmd(stop_cmd),
        .init_done(init_done), .spnd_wr(spnd_wr), .fast_en(fast_en),
        .tx_dma_busy(tx_dma_busy), .tx_mac_busy(tx_mac_busy),
        .rx_mac_busy(rx_mac_busy), .rx_dma_busy(rx_dma_busy),
        .tx_q_empty(tx_q_empty), .rx_q_empty(rx_q_empty),
        .hold_tx_fetch(hold_tx_fetch), .hold_tx_launch(hold_tx_launch),
        .hold_rx_accept(hold_rx_accept), .hold_rx_store(hold_rx_store),
        .flush_req(flush_req), .spnd_rd(spnd_rd), .need_init(need_init)
    );

    // {tx_fetch, tx_launch, rx_accept, rx_store, flush, spnd_rd, need_init}
    function automatic logic [6:0] exp_out(int st, logic fast, logic ni);
        logic [3:0] h;
        logic fl;
        h  = 4'b0000;
        fl = 1'b0;
        if (st == 3) h = 4'b1111;
        if (st == 1 || st == 2) begin
            h  = fast ? 4'b1111 : 4'b1010;
            fl = !fast;
        end
        return {h, fl, (st == 3), ni};
    endfunction

    function automatic string auto_tag(int st, logic fast, logic ni);
        if (st == 1) return fast ? "R3" : "R4";
        if (st == 2) return "R5";
        if (st == 3) return "R6";
        if (st == 4) return "R7";
        if (ni)      return "R11";
        return "R2";
    endfunction

    function automatic logic [6:0] act_out();
        return {hold_tx_fetch, hold_tx_launch, hold_rx_accept, hold_rx_store,
                flush_req, spnd_rd, need_init};
    endfunction

    task automatic model_edge();
        logic kill;
        int   nx;
        logic dd;
        logic fd;
        kill = soft_rst || stop_cmd;
        nx   = m_st;
        if (m_fast) dd = !tx_dma_busy && !tx_mac_busy && !rx_mac_busy && !rx_dma_busy;
        else        dd = !tx_dma_busy && !rx_mac_busy;
        fd = tx_q_empty && rx_q_empty && !tx_mac_busy && !rx_dma_busy;
        if (rst) begin
            m_st = 0; m_fast = 1'b0; m_init = 1'b1;
        end else begin
            if (kill) nx = 0;
            else case (m_st)
                0: if (spnd_wr && !m_init) begin nx = 1; m_fast = fast_en; end
                1: if (!spnd_wr) nx = 0; else if (dd) nx = m_fast ? 3 : 2;
                2: if (!spnd_wr) nx = 0; else if (fd) nx = 3;
                3: if (!spnd_wr) nx = 4;
                default: nx = 0;
            endcase
            if (kill) m_init = 1'b1;
            else if (init_done) m_init = 1'b0;
            m_st = nx;
        end
    endtask

    task automatic cmp(string tag, logic [6:0] a, logic [6:0] e);
        n_checks++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b", tag, a, e);
        end
    endtask

    task automatic step(string tag);
        string t;
        @(posedge clk);
        model_edge();
        #2;
        t = (tag == "") ? auto_tag(m_st, m_fast, m_init) : tag;
        cmp(t, act_out(), exp_out(m_st, m_fast, m_init));
    endtask

    task automatic quiet();
        soft_rst = 0; stop_cmd = 0; init_done = 0;
        tx_dma_busy = 0; tx_mac_busy = 0; rx_mac_busy = 0; rx_dma_busy = 0;
        tx_q_empty = 1; rx_q_empty = 1;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1; spnd_wr = 0; fast_en = 0;
        quiet();
        step("R1");
        step("R1");
        cmp("R1", act_out(), 7'b0000001);
        rst = 0;
        step("R1");

        // request ignored while uninitialized
        spnd_wr = 1;
        step("R11");
        step("R11");
        cmp("R11", act_out(), 7'b0000001);
        spnd_wr = 0; init_done = 1;
        step("R11");
        cmp("R11", act_out(), 7'b0000000);
        init_done = 0;

        // fast entry, mode change ignored, queues left full
        fast_en = 1; tx_mac_busy = 1; tx_q_empty = 0; spnd_wr = 1;
        step("R3");
        cmp("R3", act_out(), 7'b1111000);
        fast_en = 0;
        step("R8");
        cmp("R3", act_out(), 7'b1111000);
        tx_mac_busy = 0;
        step("R8");
        cmp("R8", act_out(), 7'b1111010);
        step("R6");
        cmp("R6", act_out(), 7'b1111010);
        spnd_wr = 0;
        step("R7");
        cmp("R7", act_out(), 7'b0000000);
        step("R7");
        cmp("R7", act_out(), 7'b0000000);
        tx_q_empty = 1;

        // normal entry with two stages
        fast_en = 0; rx_mac_busy = 1; rx_q_empty = 0; spnd_wr = 1;
        step("R4");
        cmp("R4", act_out(), 7'b1010100);
        step("R4");
        cmp("R4", act_out(), 7'b1010100);
        rx_mac_busy = 0; fast_en = 1;
        step("R5");
        cmp("R5", act_out(), 7'b1010100);
        step("R8");
        cmp("R8", act_out(), 7'b1010100);
        rx_q_empty = 1;
        step("R5");
        cmp("R5", act_out(), 7'b1111010);

        // stop while suspended
        stop_cmd = 1;
        step("R10");
        cmp("R10", act_out(), 7'b0000001);
        stop_cmd = 0; spnd_wr = 0; init_done = 1;
        step("R11");
        init_done = 0;

        // abort during drain
        fast_en = 1; rx_dma_busy = 1; spnd_wr = 1;
        step("R9");
        cmp("R9", act_out(), 7'b1111000);
        spnd_wr = 0;
        step("R9");
        cmp("R9", act_out(), 7'b0000000);
        rx_dma_busy = 0;

        // soft reset during normal drain
        fast_en = 0; tx_dma_busy = 1; spnd_wr = 1;
        step("R4");
        soft_rst = 1;
        step("R10");
        cmp("R10", act_out(), 7'b0000001);
        quiet(); spnd_wr = 0; init_done = 1;
        step("R11");
        init_done = 0;

        // constrained random phase
        void'($urandom(32'h5eed_0c1a));
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom();
            if (r[7:0] < 8'd20) spnd_wr = ~spnd_wr;
            fast_en     = r[8];
            tx_dma_busy = (r[11:9]  < 3'd3);
            tx_mac_busy = (r[14:12] < 3'd3);
            rx_mac_busy = (r[17:15] < 3'd3);
            rx_dma_busy = (r[20:18] < 3'd3);
            tx_q_empty  = (r[22:21] != 2'd0);
            rx_q_empty  = (r[24:23] != 2'd0);
            soft_rst    = (r[31:25] == 7'd0);
            stop_cmd    = (r[31:25] == 7'd1);
            init_done   = (r[31:25] < 7'd12) && (r[31:25] > 7'd1);
            step("");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule